// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Condition Flags

This block is the arithmetic and logic stage of a small load/store processor. It accepts two 16-bit operands and a 2-bit operation code selecting addition, subtraction, bitwise AND or bitwise OR. The result is returned combinationally in the same cycle.

In parallel, the block derives four condition bits from that result: negative, zero, carry and overflow. It keeps these bits in a flag register. The control logic raises `flag_we` for instructions that should record their condition bits. It leaves `flag_we` low for register moves, byte loads, memory loads and stores, and the stored flags then keep their previous values. When an AND or OR is recorded, carry and overflow are written as zero.

Top module: `alu_flags_core`

## Requirements
- R1: With `op_sel` = 2'b00, `result` equals `op_a + op_b` modulo 2^16, in the same cycle.
- R2: With `op_sel` = 2'b01, `result` equals `op_a - op_b` modulo 2^16, in the same cycle.
- R3: With `op_sel` = 2'b10, `result` is `op_a & op_b`. With `op_sel` = 2'b11, `result` is `op_a | op_b`. Both are available in the same cycle.
- R4: On a rising edge with `flag_we` high, `flag_z` becomes 1 exactly when the 16-bit result in that cycle is zero.
- R5: On a rising edge with `flag_we` high, `flag_n` becomes bit 15 of the result in that cycle.
- R6: For addition, a recorded `flag_c` is the unsigned carry out of bit 15. A recorded `flag_v` is 1 exactly when both operands have the same sign and the sign of the result differs from it.
- R7: For subtraction, a recorded `flag_c` is the carry out of `op_a + ~op_b + 1`, so 1 means no borrow (`op_a >= op_b` unsigned). A recorded `flag_v` is 1 exactly when the operand signs differ and the sign of the result differs from the sign of `op_a`.
- R8: For AND and OR, a recorded `flag_c` and `flag_v` are both 0, whatever their previous values.
- R9: On a rising edge with `flag_we` low, all four flags keep their values, whatever the operands and operation.
- R10: While `rst_n` is low, all four flags are 0 (asynchronous reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 AND, 11 OR |
| flag_we | input | 1 | Records the current condition bits at the next rising edge |
| result | output | 16 | Combinational operation result |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
Within one cycle, the result of the operation now on the inputs coexists with the flags stored from an earlier operation. The bench therefore checks `result` just after it drives new operands, and checks the flags only after the following edge. It interleaves cycles where `flag_we` is high with cycles where it is low, using operands that would change every flag. A hold that leaked, or a flag taken from the wrong cycle, then shows up as a mismatch. It also places a logic operation right after an arithmetic one that set carry and overflow, which shows whether those two bits are cleared in the cycle they are recorded.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cond_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [MSB:0] b_eff;
    logic [WIDTH:0] wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum   = wide[MSB:0];
        carry = wide[WIDTH];
        // signed overflow: same-signed effective operands, result sign flipped
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             use_or,
    output logic [WIDTH-1:0] res
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign res[i] = use_or ? (a[i] | b[i]) : (a[i] & b[i]);
    end
endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [1:0]       op_sel,
    input  logic             flag_we,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);
    localparam int MSB = WIDTH - 1;

    alu_op_e      op_e;
    logic [MSB:0] arith_res;
    logic [MSB:0] logic_res;
    logic         arith_carry;
    logic         arith_ovf;
    logic         is_arith;
    cond_flags_t  cand;
    cond_flags_t  flags_d;
    cond_flags_t  flags_q;

    assign op_e     = alu_op_e'(op_sel);
    assign is_arith = (op_e == OP_ADD) || (op_e == OP_SUB);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a     (op_a),
        .b     (op_b),
        .sub   (op_e == OP_SUB),
        .sum   (arith_res),
        .carry (arith_carry),
        .ovf   (arith_ovf)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a      (op_a),
        .b      (op_b),
        .use_or (op_e == OP_OR),
        .res    (logic_res)
    );

    always_comb begin
        result  = is_arith ? arith_res : logic_res;
        cand.n  = result[MSB];
        cand.z  = (result == '0);
        cand.c  = is_arith ? arith_carry : 1'b0;
        cand.v  = is_arith ? arith_ovf   : 1'b0;
        flags_d = flag_we ? cand : flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && result == '0) |=> flag_z);

    assert_sign_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flag_n == $past(result[MSB])));

    assert_logic_clears_cv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel[1]) |=> (!flag_c && !flag_v));

    assert_add_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == 2'b00 && !op_a[MSB] && !op_b[MSB] && result[MSB]) |=> flag_v);

    assert_sub_noborrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == 2'b01 && op_a == op_b) |=> (flag_c && flag_z && !flag_v));

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |-> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000));
endmodule

// File: tb/alu_flags_core_test.sv
module alu_flags_core_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [1:0]  op_sel = 2'b00;
    logic        flag_we = 1'b0;
    logic [15:0] result;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int errors = 0;
    logic [3:0] model_flags = 4'b0000;  // {n,z,c,v}

    typedef struct {
        logic [3:0] flags;
        string      tag;
    } exp_item_t;
    exp_item_t exp_q[$];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_flags_core uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .flag_we(flag_we), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: applies one operation, checks result now, queues the flags expected after the edge
    task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [1:0] sel,
                         input logic we, input string tag);
        logic [15:0] exp_res;
        logic [3:0]  cand;
        int          sa, sb, sr;
        exp_item_t   it;
        @(negedge clk);
        op_a = a; op_b = b; op_sel = sel; flag_we = we;
        sa = $signed(a); sb = $signed(b);
        case (sel)
            2'b00: begin
                exp_res = a + b; sr = sa + sb;
                cand = {exp_res[15], exp_res == 0, (17'(a) + 17'(b)) > 17'hFFFF,
                        (sr > 32767) || (sr < -32768)};
            end
            2'b01: begin
                exp_res = a - b; sr = sa - sb;
                cand = {exp_res[15], exp_res == 0, a >= b, (sr > 32767) || (sr < -32768)};
            end
            2'b10: begin exp_res = a & b; cand = {exp_res[15], exp_res == 0, 2'b00}; end
            default: begin exp_res = a | b; cand = {exp_res[15], exp_res == 0, 2'b00}; end
        endcase
        #1;
        check(result === exp_res, {tag, " result"}, result, exp_res);
        if (we) model_flags = cand;
        it.flags = model_flags;
        it.tag   = tag;
        exp_q.push_back(it);
        @(posedge clk);
    endtask

    // monitor: after each edge, compare stored flags with the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                logic [3:0] act;
                it  = exp_q.pop_front();
                act = {flag_n, flag_z, flag_c, flag_v};
                check(act === it.flags, {it.tag, " flags"}, {12'h0, act}, {12'h0, it.flags});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({flag_n, flag_z, flag_c, flag_v} === 4'b0000, "R10 reset flags",
              {12'h0, flag_n, flag_z, flag_c, flag_v}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check({flag_n, flag_z, flag_c, flag_v} === 4'b0000, "R10 after release",
              {12'h0, flag_n, flag_z, flag_c, flag_v}, 16'h0);

        drive(16'd10,   16'd20,   2'b00, 1, "R1 add plain");
        drive(16'hFFFF, 16'h0001, 2'b00, 1, "R1 R4 R6 add carry to zero");
        drive(16'h7FFF, 16'h0001, 2'b00, 1, "R5 R6 add signed overflow");
        drive(16'h8000, 16'h8000, 2'b00, 1, "R6 add neg overflow");
        drive(16'd10,   16'd20,   2'b01, 1, "R2 R7 sub borrow");
        drive(16'd5,    16'd5,    2'b01, 1, "R4 R7 sub equal");
        drive(16'h8000, 16'h0001, 2'b01, 1, "R7 sub overflow");
        drive(16'h000C, 16'h000A, 2'b10, 1, "R3 R8 and after overflow");
        drive(16'hFFFF, 16'h0001, 2'b00, 1, "R6 set carry");
        drive(16'h00F0, 16'h000F, 2'b10, 1, "R4 R8 and zero clears cv");
        drive(16'h000C, 16'h000A, 2'b11, 1, "R3 or");
        drive(16'h8000, 16'h0001, 2'b11, 1, "R5 R8 or negative");
        drive(16'h7FFF, 16'h0001, 2'b00, 1, "R6 prime flags");
        drive(16'd3,    16'd3,    2'b01, 0, "R9 hold sub equal");
        drive(16'h0000, 16'h0000, 2'b10, 0, "R9 hold and zero");
        drive(16'hFFFF, 16'h0001, 2'b00, 0, "R9 hold add carry");
        for (int i = 0; i < 60; i++) begin
            drive(16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom), "R1 R2 R3 R7 R9 mixed");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule